// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Code Register

This block sits between a byte-wide processor bus and a two-channel 12-bit converter. A channel's 12-bit code arrives as two byte writes, one for the low byte and one for the high part. Each write lands in that channel's staging register. A shared load strobe copies the staging contents of both channels into their output registers in the same clock edge. Those output registers drive the converter, so both channels can change at the same moment.

Two ways of using the block follow from this. In pass-through use, the load strobe is held active. The second byte written to a channel then reaches its output register in the same edge, so updating both channels takes four bus cycles. In strobed use, four writes fill both staging registers while the load strobe is inactive, and a fifth cycle pulses the load to update both outputs together.

The level-sensitive latches of an asynchronous part are modelled here as registers clocked on the rising edge of `clk`. All control inputs are sampled on that edge, and the clear is synchronous.

Top module: `dacif_dual`

## Requirements
- R1: When `clr_n` is low at a clock edge, both staging registers and both output codes become zero after that edge, whatever the other inputs are.
- R2: A write (`wr_n` low) with `chan_sel` = 0 and `hi_sel` = 0 loads `bus_data[7:0]` into bits 7:0 of channel A's staging word only.
- R3: A write with `chan_sel` = 0 and `hi_sel` = 1 loads `bus_data[3:0]` into bits 11:8 of channel A's staging word, and `bus_data[7:4]` are ignored.
- R4: With `chan_sel` = 1, the same writes go to channel B's staging word instead of channel A's.
- R5: Every staging part that is not selected holds its value. When `wr_n` is high, every staging part holds its value.
- R6: When `ld_n` is low, both output codes take their channel's staging word, whatever the values of `chan_sel`, `hi_sel` and `wr_n`.
- R7: When `ld_n` is high, both output codes hold their value, even while staging registers are being written.
- R8: When a byte write and an active load fall in the same edge, the output code includes the byte being written. With `ld_n` held low, four writes therefore update both channels.
- R9: With `ld_n` high, four writes fill both staging words while the outputs stay unchanged. One edge with `ld_n` low then updates both outputs together.
- R10: After `clr_n` rises while `wr_n` is high, all registers keep their zero values until a write occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low |
| bus_data | input | 8 | Byte-wide write data |
| chan_sel | input | 1 | Channel select: 0 selects A, 1 selects B |
| wr_n | input | 1 | Byte write strobe, active low |
| hi_sel | input | 1 | Byte select: 0 selects the low byte, 1 selects the high part |
| ld_n | input | 1 | Load strobe for both output registers, active low |
| code_a | output | 12 | Channel A output code |
| code_b | output | 12 | Channel B output code |

## Verification
The bench runs directed pass-through sequences, with `ld_n` held low, and strobed sequences of four writes followed by a load. Comparing the two shows whether the load source is the staging word after the write or the old staging word. Loads issued with unrelated select values, and with no write, show whether the load depends on the selects and whether a write leaks into the wrong byte or channel. High bytes are written with their upper nibble set, which exposes any use of the ignored bits. Constrained random traffic, with occasional clears in the middle of a sequence, is compared every cycle against a reference model held in the bench.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  // number of converter channels served by one instance
  localparam int NUM_CH = 2;

  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } chan_e;

  // per-channel byte write enables produced by the decoder
  typedef struct packed {
    logic hi;
    logic lo;
  } byte_we_t;
endpackage

// File: rtl/dacif_decode.sv
module dacif_decode
  import dacif_pkg::*;
#(
  parameter int N_CH = NUM_CH
) (
  input  logic                   wr_n,
  input  logic                   chan_sel,
  input  logic                   hi_sel,
  output byte_we_t [N_CH-1:0]    we
);
  // one write strobe to at most one byte part of one channel
  for (genvar c = 0; c < N_CH; c++) begin : g_dec
    logic hit;
    assign hit      = !wr_n && (chan_sel == c[0]);
    assign we[c].lo = hit && !hi_sel;
    assign we[c].hi = hit &&  hi_sel;
  end
endmodule

// File: rtl/dacif_slice.sv
module dacif_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);
  // value the slice takes at the coming edge, offered to the load path
  always_comb begin
    if (clr)     q_next = '0;
    else if (we) q_next = d;
    else         q_next = q;
  end

  always_ff @(posedge clk) begin
    q <= q_next;
  end
endmodule

// File: rtl/dacif_chan.sv
module dacif_chan
  import dacif_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              clr,
  input  byte_we_t          we,
  input  logic              ld,
  input  logic [DATA_W-1:0] bus_data,
  output logic [CODE_W-1:0] stage_word,
  output logic [CODE_W-1:0] code
);
  localparam int HI_W = CODE_W - DATA_W;

  logic [DATA_W-1:0] lo_q, lo_n;
  logic [HI_W-1:0]   hi_q, hi_n;

  dacif_slice #(.W(DATA_W)) u_lo (
    .clk   (clk),
    .clr   (clr),
    .we    (we.lo),
    .d     (bus_data),
    .q     (lo_q),
    .q_next(lo_n)
  );

  // only the low HI_W bits of the bus reach the upper part
  dacif_slice #(.W(HI_W)) u_hi (
    .clk   (clk),
    .clr   (clr),
    .we    (we.hi),
    .d     (bus_data[HI_W-1:0]),
    .q     (hi_q),
    .q_next(hi_n)
  );

  assign stage_word = {hi_q, lo_q};

  // output rank reads the next-state staging word (latch transparency)
  always_ff @(posedge clk) begin
    if (clr)     code <= '0;
    else if (ld) code <= {hi_n, lo_n};
  end
endmodule

// File: rtl/dacif_dual.sv
module dacif_dual
  import dacif_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              chan_sel,
  input  logic              wr_n,
  input  logic              hi_sel,
  input  logic              ld_n,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b
);
  logic clr, ld;
  byte_we_t [NUM_CH-1:0] we;
  logic [NUM_CH-1:0][CODE_W-1:0] stage_vec;
  logic [NUM_CH-1:0][CODE_W-1:0] code_vec;
  logic [CODE_W-1:0] stage_a, stage_b;

  assign clr = !clr_n;
  assign ld  = !ld_n;

  dacif_decode #(.N_CH(NUM_CH)) u_dec (
    .wr_n    (wr_n),
    .chan_sel(chan_sel),
    .hi_sel  (hi_sel),
    .we      (we)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dacif_chan #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_ch (
      .clk       (clk),
      .clr       (clr),
      .we        (we[c]),
      .ld        (ld),
      .bus_data  (bus_data),
      .stage_word(stage_vec[c]),
      .code      (code_vec[c])
    );
  end

  assign code_a  = code_vec[CH_A];
  assign code_b  = code_vec[CH_B];
  assign stage_a = stage_vec[CH_A];
  assign stage_b = stage_vec[CH_B];
endmodule

// File: rtl/dacif_dual_chk.sv
module dacif_dual_chk #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              clr_n,
  input logic [DATA_W-1:0] bus_data,
  input logic              chan_sel,
  input logic              wr_n,
  input logic              hi_sel,
  input logic              ld_n,
  input logic [CODE_W-1:0] code_a,
  input logic [CODE_W-1:0] code_b,
  input logic [CODE_W-1:0] stage_a,
  input logic [CODE_W-1:0] stage_b
);
  localparam int HI_W = CODE_W - DATA_W;

  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  // R1
  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!started)
    !clr_n |=> (code_a == '0 && code_b == '0 && stage_a == '0 && stage_b == '0));

  assert_low_byte_R2: assert property (@(posedge clk) disable iff (!clr_n)
    (!wr_n && !chan_sel && !hi_sel) |=>
      (stage_a[DATA_W-1:0] == $past(bus_data) &&
       stage_a[CODE_W-1:DATA_W] == $past(stage_a[CODE_W-1:DATA_W])));

  assert_high_nibble_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (!wr_n && !chan_sel && hi_sel) |=>
      (stage_a[CODE_W-1:DATA_W] == $past(bus_data[HI_W-1:0]) &&
       stage_a[DATA_W-1:0] == $past(stage_a[DATA_W-1:0])));

  assert_steer_other_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (!wr_n && chan_sel) |=> $stable(stage_a));

  assert_unsel_hold_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (!wr_n && !chan_sel) |=> $stable(stage_b));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!clr_n)
    wr_n |=> ($stable(stage_a) && $stable(stage_b)));

  assert_load_both_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (!ld_n && wr_n) |=> (code_a == $past(stage_a) && code_b == $past(stage_b)));

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!clr_n)
    ld_n |=> ($stable(code_a) && $stable(code_b)));

  assert_pass_through_R8: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> (code_a == stage_a && code_b == stage_b));
endmodule

bind dacif_dual dacif_dual_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
  .clk     (clk),
  .clr_n   (clr_n),
  .bus_data(bus_data),
  .chan_sel(chan_sel),
  .wr_n    (wr_n),
  .hi_sel  (hi_sel),
  .ld_n    (ld_n),
  .code_a  (code_a),
  .code_b  (code_b),
  .stage_a (stage_a),
  .stage_b (stage_b)
);

// File: tb/dacif_dual_test.sv
`timescale 1ns/1ps
module dacif_dual_test;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic [7:0] bus_data = '0;
  logic       chan_sel = 1'b0;
  logic       wr_n = 1'b1;
  logic       hi_sel = 1'b0;
  logic       ld_n = 1'b1;
  logic [11:0] code_a, code_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0] m_lo [2];
  logic [3:0] m_hi [2];
  logic [11:0] m_out [2];

  always #4 clk = ~clk;

  dacif_dual uut (
    .clk(clk), .clr_n(clr_n), .bus_data(bus_data), .chan_sel(chan_sel),
    .wr_n(wr_n), .hi_sel(hi_sel), .ld_n(ld_n), .code_a(code_a), .code_b(code_b)
  );

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
    end
  endtask

  // model of the requirements: clear, byte writes, load from post-write word
  task automatic model(input logic c, input logic [7:0] d, input logic ch,
                       input logic w, input logic h, input logic l);
    logic [7:0] nlo [2];
    logic [3:0] nhi [2];
    for (int i = 0; i < 2; i++) begin nlo[i] = m_lo[i]; nhi[i] = m_hi[i]; end
    if (!c) begin
      for (int i = 0; i < 2; i++) begin m_lo[i] = '0; m_hi[i] = '0; m_out[i] = '0; end
    end else begin
      if (!w) begin
        if (h) nhi[ch] = d[3:0];
        else   nlo[ch] = d;
      end
      for (int i = 0; i < 2; i++) begin
        if (!l) m_out[i] = {nhi[i], nlo[i]};
        m_lo[i] = nlo[i];
        m_hi[i] = nhi[i];
      end
    end
  endtask

  task automatic step(input logic c, input logic [7:0] d, input logic ch,
                      input logic w, input logic h, input logic l, input string tag);
    @(negedge clk);
    clr_n = c; bus_data = d; chan_sel = ch; wr_n = w; hi_sel = h; ld_n = l;
    @(posedge clk);
    model(c, d, ch, w, h, l);
    #2;
    chk({tag, " chA"}, code_a, m_out[0]);
    chk({tag, " chB"}, code_b, m_out[1]);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin m_lo[i] = '0; m_hi[i] = '0; m_out[i] = '0; end
    // R1: clear overrides a write and a load in the same edge
    step(0, 8'hFF, 0, 0, 0, 0, "R1");
    chk("R1 lit", code_a, 12'h000);
    // R10: release with write idle, then load keeps zeros
    step(1, 8'h77, 1, 1, 1, 0, "R10");
    chk("R10 lit", code_b, 12'h000);
    // R2 and R7: low byte of A staged, outputs hold
    step(1, 8'hA5, 0, 0, 0, 1, "R7");
    chk("R7 lit", code_a, 12'h000);
    step(1, 8'h00, 1, 1, 1, 0, "R2");
    chk("R2 lit", code_a, 12'h0A5);
    chk("R5 lit", code_b, 12'h000);
    // R3: upper nibble ignored
    step(1, 8'hE7, 0, 0, 1, 1, "R3");
    step(1, 8'h00, 0, 1, 0, 0, "R3");
    chk("R3 lit", code_a, 12'h7A5);
    // R4: channel B
    step(1, 8'h3C, 1, 0, 0, 1, "R4");
    step(1, 8'h19, 1, 0, 1, 1, "R4");
    step(1, 8'h00, 0, 1, 1, 0, "R4");
    chk("R4 lit", code_b, 12'h93C);
    chk("R5 lit A", code_a, 12'h7A5);
    // R6: load with unrelated selects still updates B
    step(1, 8'h00, 1, 0, 0, 1, "R6");
    step(1, 8'hFF, 0, 1, 1, 0, "R6");
    chk("R6 lit", code_b, 12'h900);
    // R8: pass-through, four cycles
    step(1, 8'h11, 0, 0, 0, 0, "R8");
    chk("R8 lit lo", code_a, 12'h711);
    step(1, 8'hF2, 0, 0, 1, 0, "R8");
    chk("R8 lit hi", code_a, 12'h211);
    step(1, 8'h44, 1, 0, 0, 0, "R8");
    step(1, 8'h03, 1, 0, 1, 0, "R8");
    chk("R8 lit B", code_b, 12'h344);
    // R9: strobed, four writes then one load
    step(1, 8'hAB, 0, 0, 0, 1, "R9");
    step(1, 8'h05, 0, 0, 1, 1, "R9");
    step(1, 8'hCD, 1, 0, 0, 1, "R9");
    step(1, 8'h0E, 1, 0, 1, 1, "R9");
    chk("R9 hold A", code_a, 12'h211);
    chk("R9 hold B", code_b, 12'h344);
    step(1, 8'h00, 0, 1, 0, 0, "R9");
    chk("R9 lit A", code_a, 12'h5AB);
    chk("R9 lit B", code_b, 12'hECD);
    // R1 in mid sequence: staged data discarded
    step(1, 8'h66, 0, 0, 0, 1, "R1");
    step(0, 8'h66, 1, 0, 1, 1, "R1");
    step(1, 8'h00, 0, 1, 0, 0, "R1");
    chk("R1 mid A", code_a, 12'h000);
    chk("R1 mid B", code_b, 12'h000);
    // random traffic against the model (R5 R6 R7 R8 mixed)
    void'($urandom(32'd2024));
    for (int n = 0; n < 4000; n++) begin
      logic c, ch, w, h, l;
      c  = ($urandom % 40) != 0;
      ch = $urandom % 2;
      w  = ($urandom % 3) == 0;
      h  = $urandom % 2;
      l  = ($urandom % 4) != 0;
      step(c, 8'($urandom), ch, w, h, l, "R6 rnd");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule